// File: doc/BRIEF.md
# Graphics Memory Aperture Decoder

This block sits between the host memory bus and the video memory of a VGA-compatible graphics controller. It looks at the configuration fields that pick the memory map and, for each host memory access, decides which of three windows the address falls in. The three windows are a banked legacy window in the low 1 MB region, a linear frame-buffer aperture, and a 256-byte window onto the controller's memory-mapped registers. For a hit it returns the video-memory offset, or the register index for the register window. Addresses outside every live window are reported as a miss.

A nonzero 4-bit linear-select field switches the controller from the legacy banked map to the linear aperture. Where the aperture sits and how large it is depends on the chip generation and the attachment bus, and elaboration parameters fix those two choices. The result is registered, so it appears one clock after the access is presented. The configuration in force is the one present together with the access.

Top module: `gfx_aperture_decode`

## Requirements
- R1: While `mem_en` is 0, no window responds: a valid access returns `hit_legacy`, `hit_linear` and `hit_mmio` all 0 and `miss` = 1.
- R2: With `mem_en` = 1 and `lin_sel` = 0, the legacy window depends on `leg_mode`. Modes 2'b00 and 2'b01 cover 0xA0000..0xAFFFF with offset mask 0xFFFF. Mode 2'b10 covers 0xB0000..0xB7FFF with mask 0x7FFF. Mode 2'b11 covers 0xB8000..0xBFFFF with mask 0x7FFF.
- R3: The legacy offset is built in three steps. The address is ANDed with the mode's mask. Bit 15 of the result selects `bank1_ofs` (1) or `bank0_ofs` (0). The selected bank offset is added to bits 14:0, and the sum is truncated to OFFS_W bits.
- R4: The register window 0xB8000..0xB80FF is live only when `mem_en` = 1 and `mmio_decode_en` = 1, and also either `leg_mode` = 2'b01 or `lin_sel` is nonzero. On a hit, `vmem_ofs` carries address bits 7:0.
- R5: In the older-generation variant (NEW_GEN = 0), the aperture starts at `lin_sel` placed in address bits 23:20. It spans 1 MB when `lin_small` = 1 and 2 MB when `lin_small` = 0. The offset is the address minus the base.
- R6: In the newer-generation variant on PCI (NEW_GEN = 1, ON_PCI = 1), the aperture base has bits 31:24 equal to `pci_base_hi` and bits 23:0 equal to zero. The aperture spans 4 MB.
- R7: In the newer-generation variant on a local bus (NEW_GEN = 1, ON_PCI = 0), the aperture spans 4 MB from the fixed base 0x0800_0000.
- R8: While `lin_sel` is nonzero, the legacy window never responds, even for addresses in 0xA0000..0xBFFFF.
- R9: A valid access is answered on the clock edge that follows it. `hit_valid` = 1 and the flags reflect the address and configuration sampled with the access. A cycle without `acc_valid` leaves `hit_valid` and all flags at 0. After reset, all outputs are 0.
- R10: At most one of `hit_legacy`, `hit_linear`, `hit_mmio` and `miss` is 1. `miss` = 1 exactly for a valid access that no live window claims, and `vmem_ofs` is 0 whenever no window hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| acc_valid | input | 1 | Host memory access present this cycle |
| acc_addr | input | ADDR_W | Host byte address |
| mem_en | input | 1 | Bus memory-space enable |
| lin_sel | input | 4 | Linear-select field; 0 selects the legacy map |
| lin_small | input | 1 | Older generation: 1 MB aperture when set, 2 MB when clear |
| pci_base_hi | input | 8 | Aperture base bits 31:24 for the PCI variant |
| leg_mode | input | 2 | Legacy window mode |
| mmio_decode_en | input | 1 | Register-window enable (bit 2 of the register-window control register) |
| bank0_ofs | input | OFFS_W | Bank offset used when masked address bit 15 is 0 |
| bank1_ofs | input | OFFS_W | Bank offset used when masked address bit 15 is 1 |
| hit_valid | output | 1 | Registered response to an access |
| hit_legacy | output | 1 | Access hit the legacy window |
| hit_linear | output | 1 | Access hit the linear aperture |
| hit_mmio | output | 1 | Access hit the register window |
| miss | output | 1 | Valid access claimed by no window |
| vmem_ofs | output | OFFS_W | Translated offset or register index |

## Verification
The bench targets the edges of each window. These are the last byte of the 32 KB legacy windows against the first byte of the next, the register window inside the 0xB8000 legacy window in mode 2'b11, and the first address past a 1 MB aperture that a 2 MB aperture still covers. A decoder that compared with the wrong span would hit one byte past a window or miss its last byte. If the decoder chose the bank from the unmasked address, 32 KB modes would add `bank1_ofs` for addresses such as 0xB8000. If the decoder gated the legacy window on mode only, it would answer alongside the aperture. Back-to-back accesses with a configuration change between them show a decoder that latches configuration late.

// File: rtl/gad_pkg.sv
package gad_pkg;

   localparam int LIN_SEL_W   = 4;
   localparam int PCI_HI_W    = 8;
   localparam int BANK_LOW_W  = 15;
   localparam int MMIO_IDX_W  = 8;
   localparam int MIN_OFFS_W  = 22;
   localparam int MIN_ADDR_W  = 32;

   localparam logic [31:0] LEG_A0_BASE   = 32'h000A_0000;
   localparam logic [31:0] LEG_B0_BASE   = 32'h000B_0000;
   localparam logic [31:0] LEG_B8_BASE   = 32'h000B_8000;
   localparam logic [31:0] LEG_SPAN_64K  = 32'h0001_0000;
   localparam logic [31:0] LEG_SPAN_32K  = 32'h0000_8000;
   localparam logic [15:0] LEG_MASK_64K  = 16'hFFFF;
   localparam logic [15:0] LEG_MASK_32K  = 16'h7FFF;

   localparam logic [31:0] MMIO_BASE     = 32'h000B_8000;
   localparam logic [31:0] MMIO_SPAN     = 32'h0000_0100;

   localparam logic [31:0] APT_SPAN_1M   = 32'h0010_0000;
   localparam logic [31:0] APT_SPAN_2M   = 32'h0020_0000;
   localparam logic [31:0] APT_SPAN_4M   = 32'h0040_0000;
   localparam logic [31:0] APT_LOCAL_BASE = 32'h0800_0000;

   typedef enum logic [1:0] {
      LEG_A0_BANKED = 2'b00,
      LEG_A0_REGWIN = 2'b01,
      LEG_B0_MONO   = 2'b10,
      LEG_B8_TEXT   = 2'b11
   } leg_mode_e;

   typedef struct packed {
      logic legacy;
      logic linear;
      logic mmio;
      logic miss;
   } hit_flags_t;

   typedef struct packed {
      logic [31:0] base;
      logic [31:0] span;
      logic [15:0] mask;
   } leg_win_t;

   function automatic leg_win_t leg_window(input leg_mode_e m);
      leg_win_t w;
      unique case (m)
         LEG_A0_BANKED, LEG_A0_REGWIN: w = '{base: LEG_A0_BASE, span: LEG_SPAN_64K, mask: LEG_MASK_64K};
         LEG_B0_MONO:                  w = '{base: LEG_B0_BASE, span: LEG_SPAN_32K, mask: LEG_MASK_32K};
         default:                      w = '{base: LEG_B8_BASE, span: LEG_SPAN_32K, mask: LEG_MASK_32K};
      endcase
      return w;
   endfunction

endpackage

// File: rtl/gad_legacy_win.sv
module gad_legacy_win
   import gad_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 22
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              win_en,
   input  leg_mode_e         mode,
   input  logic [OFFS_W-1:0] bank0_ofs,
   input  logic [OFFS_W-1:0] bank1_ofs,
   output logic              hit,
   output logic [OFFS_W-1:0] ofs
);

   leg_win_t            win;
   logic [ADDR_W-1:0]   base_ext;
   logic [ADDR_W-1:0]   span_ext;
   logic [ADDR_W-1:0]   rel;
   logic [15:0]         masked;
   logic [OFFS_W-1:0]   bank_sel;

   always_comb begin
      win      = leg_window(mode);
      base_ext = ADDR_W'(win.base);
      span_ext = ADDR_W'(win.span);
      rel      = addr - base_ext;
      hit      = win_en && (addr >= base_ext) && (rel < span_ext);
      masked   = addr[15:0] & win.mask;
      bank_sel = masked[15] ? bank1_ofs : bank0_ofs;
      ofs      = OFFS_W'(masked[BANK_LOW_W-1:0]) + bank_sel;
   end

endmodule

// File: rtl/gad_linear_win.sv
module gad_linear_win
   import gad_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OFFS_W  = 22,
   parameter bit NEW_GEN = 1'b0,
   parameter bit ON_PCI  = 1'b0
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 mem_en,
   input  logic [LIN_SEL_W-1:0] lin_sel,
   input  logic                 lin_small,
   input  logic [PCI_HI_W-1:0]  pci_base_hi,
   output logic                 apt_on,
   output logic                 hit,
   output logic [OFFS_W-1:0]    ofs
);

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] span;
   logic [ADDR_W-1:0] rel;

   generate
      if (!NEW_GEN) begin : g_old_gen
         logic unused_pci_hi;
         assign unused_pci_hi = ^pci_base_hi;
         assign base = ADDR_W'({lin_sel, 20'h0_0000});
         assign span = lin_small ? ADDR_W'(APT_SPAN_1M) : ADDR_W'(APT_SPAN_2M);
      end else if (ON_PCI) begin : g_new_pci
         logic unused_small;
         assign unused_small = lin_small;
         assign base = ADDR_W'({pci_base_hi, 24'h00_0000});
         assign span = ADDR_W'(APT_SPAN_4M);
      end else begin : g_new_local
         logic unused_cfg;
         assign unused_cfg = lin_small ^ (^pci_base_hi);
         assign base = ADDR_W'(APT_LOCAL_BASE);
         assign span = ADDR_W'(APT_SPAN_4M);
      end
   endgenerate

   always_comb begin
      apt_on = mem_en && (lin_sel != '0);
      rel    = addr - base;
      hit    = apt_on && (addr >= base) && (rel < span);
      ofs    = rel[OFFS_W-1:0];
   end

endmodule

// File: rtl/gad_mmio_win.sv
module gad_mmio_win
   import gad_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int OFFS_W = 22
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              mem_en,
   input  logic              ctl_en,
   input  leg_mode_e         mode,
   input  logic              lin_req,
   output logic              hit,
   output logic [OFFS_W-1:0] ofs
);

   logic              live;
   logic [ADDR_W-1:0] base_ext;
   logic [ADDR_W-1:0] rel;

   always_comb begin
      live     = mem_en && ctl_en && (lin_req || (mode == LEG_A0_REGWIN));
      base_ext = ADDR_W'(MMIO_BASE);
      rel      = addr - base_ext;
      hit      = live && (addr >= base_ext) && (rel < ADDR_W'(MMIO_SPAN));
      ofs      = OFFS_W'(addr[MMIO_IDX_W-1:0]);
   end

endmodule

// File: rtl/gfx_aperture_decode.sv
module gfx_aperture_decode
   import gad_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int OFFS_W  = 22,
   parameter bit NEW_GEN = 1'b0,
   parameter bit ON_PCI  = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 acc_valid,
   input  logic [ADDR_W-1:0]    acc_addr,
   input  logic                 mem_en,
   input  logic [3:0]           lin_sel,
   input  logic                 lin_small,
   input  logic [7:0]           pci_base_hi,
   input  logic [1:0]           leg_mode,
   input  logic                 mmio_decode_en,
   input  logic [OFFS_W-1:0]    bank0_ofs,
   input  logic [OFFS_W-1:0]    bank1_ofs,
   output logic                 hit_valid,
   output logic                 hit_legacy,
   output logic                 hit_linear,
   output logic                 hit_mmio,
   output logic                 miss,
   output logic [OFFS_W-1:0]    vmem_ofs
);

   generate
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
         $error("gfx_aperture_decode: ADDR_W must be at least 32");
      end
      if (OFFS_W < MIN_OFFS_W || OFFS_W > ADDR_W) begin : g_bad_offs_w
         $error("gfx_aperture_decode: OFFS_W must cover 4 MB and fit in ADDR_W");
      end
   endgenerate

   leg_mode_e         mode;
   logic              lin_req;
   logic              apt_on;
   logic              leg_hit, lin_hit, mm_hit;
   logic [OFFS_W-1:0] leg_ofs, lin_ofs, mm_ofs;
   hit_flags_t        flags_d, flags_q;
   logic [OFFS_W-1:0] ofs_d, ofs_q;
   logic              valid_q;

   assign mode    = leg_mode_e'(leg_mode);
   assign lin_req = (lin_sel != '0);

   gad_legacy_win #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_legacy (
      .addr      (acc_addr),
      .win_en    (mem_en && !lin_req),
      .mode      (mode),
      .bank0_ofs (bank0_ofs),
      .bank1_ofs (bank1_ofs),
      .hit       (leg_hit),
      .ofs       (leg_ofs)
   );

   gad_linear_win #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .NEW_GEN(NEW_GEN), .ON_PCI(ON_PCI)) u_linear (
      .addr        (acc_addr),
      .mem_en      (mem_en),
      .lin_sel     (lin_sel),
      .lin_small   (lin_small),
      .pci_base_hi (pci_base_hi),
      .apt_on      (apt_on),
      .hit         (lin_hit),
      .ofs         (lin_ofs)
   );

   gad_mmio_win #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_mmio (
      .addr    (acc_addr),
      .mem_en  (mem_en),
      .ctl_en  (mmio_decode_en),
      .mode    (mode),
      .lin_req (apt_on),
      .hit     (mm_hit),
      .ofs     (mm_ofs)
   );

   always_comb begin
      flags_d = '0;
      ofs_d   = '0;
      if (acc_valid) begin
         flags_d.legacy = leg_hit;
         flags_d.linear = lin_hit;
         flags_d.mmio   = mm_hit;
         flags_d.miss   = !(leg_hit || lin_hit || mm_hit);
         if (leg_hit)      ofs_d = leg_ofs;
         else if (lin_hit) ofs_d = lin_ofs;
         else if (mm_hit)  ofs_d = mm_ofs;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         flags_q <= '0;
         ofs_q   <= '0;
      end else begin
         valid_q <= acc_valid;
         flags_q <= flags_d;
         ofs_q   <= ofs_d;
      end
   end

   assign hit_valid  = valid_q;
   assign hit_legacy = flags_q.legacy;
   assign hit_linear = flags_q.linear;
   assign hit_mmio   = flags_q.mmio;
   assign miss       = flags_q.miss;
   assign vmem_ofs   = ofs_q;

endmodule

// File: rtl/gad_checker.sv
module gad_checker #(
   parameter int OFFS_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              mem_en,
   input logic [3:0]        lin_sel,
   input logic              mmio_decode_en,
   input logic              hit_valid,
   input logic              hit_legacy,
   input logic              hit_linear,
   input logic              hit_mmio,
   input logic              miss,
   input logic [OFFS_W-1:0] vmem_ofs
);

   p_memoff_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !mem_en) |=> (!hit_legacy && !hit_linear && !hit_mmio && miss))
      else $error("memory enable off but a window answered");

   p_mmiogate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !mmio_decode_en) |=> !hit_mmio)
      else $error("register window answered while disabled");

   p_linlegacy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && lin_sel != 4'h0) |=> !hit_legacy)
      else $error("legacy window answered with aperture selected");

   p_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> (hit_valid && (hit_legacy || hit_linear || hit_mmio || miss)))
      else $error("access not answered on the next edge");

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!hit_valid && !hit_legacy && !hit_linear && !hit_mmio && !miss))
      else $error("flags raised without an access");

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_legacy, hit_linear, hit_mmio, miss}))
      else $error("more than one outcome flag");

   p_missofs_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit_legacy || hit_linear || hit_mmio) |-> (vmem_ofs == '0))
      else $error("offset nonzero without a hit");

endmodule

bind gfx_aperture_decode gad_checker #(.OFFS_W(OFFS_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .acc_valid      (acc_valid),
   .mem_en         (mem_en),
   .lin_sel        (lin_sel),
   .mmio_decode_en (mmio_decode_en),
   .hit_valid      (hit_valid),
   .hit_legacy     (hit_legacy),
   .hit_linear     (hit_linear),
   .hit_mmio       (hit_mmio),
   .miss           (miss),
   .vmem_ofs       (vmem_ofs)
);

// File: tb/sim_gfx_aperture_decode.sv
`timescale 1ns/1ps
module sim_gfx_aperture_decode;

   localparam int AW = 32;
   localparam int OW = 22;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic          mem_en = 1'b0;
   logic [3:0]    lin_sel = '0;
   logic          lin_small = 1'b0;
   logic [7:0]    pci_base_hi = '0;
   logic [1:0]    leg_mode = '0;
   logic          mmio_decode_en = 1'b0;
   logic [OW-1:0] bank0_ofs = '0;
   logic [OW-1:0] bank1_ofs = '0;

   logic          hv [3];
   logic          hl [3];
   logic          hn [3];
   logic          hm [3];
   logic          ms [3];
   logic [OW-1:0] of [3];

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2.5 clk = ~clk;

   gfx_aperture_decode #(.ADDR_W(AW), .OFFS_W(OW), .NEW_GEN(1'b0), .ON_PCI(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr), .mem_en(mem_en),
      .lin_sel(lin_sel), .lin_small(lin_small), .pci_base_hi(pci_base_hi), .leg_mode(leg_mode),
      .mmio_decode_en(mmio_decode_en), .bank0_ofs(bank0_ofs), .bank1_ofs(bank1_ofs),
      .hit_valid(hv[0]), .hit_legacy(hl[0]), .hit_linear(hn[0]), .hit_mmio(hm[0]), .miss(ms[0]), .vmem_ofs(of[0]));

   gfx_aperture_decode #(.ADDR_W(AW), .OFFS_W(OW), .NEW_GEN(1'b1), .ON_PCI(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr), .mem_en(mem_en),
      .lin_sel(lin_sel), .lin_small(lin_small), .pci_base_hi(pci_base_hi), .leg_mode(leg_mode),
      .mmio_decode_en(mmio_decode_en), .bank0_ofs(bank0_ofs), .bank1_ofs(bank1_ofs),
      .hit_valid(hv[1]), .hit_legacy(hl[1]), .hit_linear(hn[1]), .hit_mmio(hm[1]), .miss(ms[1]), .vmem_ofs(of[1]));

   gfx_aperture_decode #(.ADDR_W(AW), .OFFS_W(OW), .NEW_GEN(1'b1), .ON_PCI(1'b0)) u2 (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr), .mem_en(mem_en),
      .lin_sel(lin_sel), .lin_small(lin_small), .pci_base_hi(pci_base_hi), .leg_mode(leg_mode),
      .mmio_decode_en(mmio_decode_en), .bank0_ofs(bank0_ofs), .bank1_ofs(bank1_ofs),
      .hit_valid(hv[2]), .hit_legacy(hl[2]), .hit_linear(hn[2]), .hit_mmio(hm[2]), .miss(ms[2]), .vmem_ofs(of[2]));

   // Expected {valid, legacy, linear, mmio, miss, offset} from the requirements.
   function automatic logic [4+OW:0] model(input int v);
      longint a, lb, ls, wb, ws;
      logic [15:0] msk, m;
      logic leg, lin, mm;
      logic [OW-1:0] o;
      a = longint'(acc_addr);
      leg = 1'b0; lin = 1'b0; mm = 1'b0; o = '0;
      case (leg_mode)
         2'b00, 2'b01: begin wb = 64'hA0000; ws = 64'h10000; msk = 16'hFFFF; end
         2'b10:        begin wb = 64'hB0000; ws = 64'h8000;  msk = 16'h7FFF; end
         default:      begin wb = 64'hB8000; ws = 64'h8000;  msk = 16'h7FFF; end
      endcase
      if (v == 0) begin
         lb = longint'(lin_sel) * 64'h100000;
         ls = lin_small ? 64'h100000 : 64'h200000;
      end else if (v == 1) begin
         lb = longint'(pci_base_hi) * 64'h1000000;
         ls = 64'h400000;
      end else begin
         lb = 64'h8000000;
         ls = 64'h400000;
      end
      if (mem_en && lin_sel == 4'h0 && a >= wb && a < wb + ws) begin
         leg = 1'b1;
         m = acc_addr[15:0] & msk;
         o = OW'({7'b0, m[14:0]}) + (m[15] ? bank1_ofs : bank0_ofs);
      end else if (mem_en && lin_sel != 4'h0 && a >= lb && a < lb + ls) begin
         lin = 1'b1;
         o = OW'(a - lb);
      end else if (mem_en && mmio_decode_en && (lin_sel != 4'h0 || leg_mode == 2'b01)
                   && a >= 64'hB8000 && a < 64'hB8100) begin
         mm = 1'b1;
         o = OW'(acc_addr[7:0]);
      end
      return {1'b1, leg, lin, mm, !(leg || lin || mm), o};
   endfunction

   function automatic string auto_tag(input int v, input logic [4+OW:0] e);
      if (!mem_en)        return "R1";
      if (e[3+OW])        return "R3";
      if (e[2+OW])        return (v == 0) ? "R5" : (v == 1) ? "R6" : "R7";
      if (e[1+OW])        return "R4";
      if (lin_sel != 4'h0) return "R8";
      return "R10";
   endfunction

   // Present one access; expect the answer at the following negedge.
   task automatic access(input logic [AW-1:0] a, input string tag);
      logic [4+OW:0] exp_v [3];
      string tg [3];
      acc_addr  = a;
      acc_valid = 1'b1;
      for (int v = 0; v < 3; v++) begin
         exp_v[v] = model(v);
         tg[v] = (tag == "") ? auto_tag(v, exp_v[v]) : tag;
      end
      @(negedge clk);
      for (int v = 0; v < 3; v++) begin
         logic [4+OW:0] act;
         act = {hv[v], hl[v], hn[v], hm[v], ms[v], of[v]};
         n_tests++;
         if (act !== exp_v[v]) begin
            n_fail++;
            $display("FAIL %s u%0d addr=%h act v/l/n/m/x=%b ofs=%h exp v/l/n/m/x=%b ofs=%h",
                     tg[v], v, a, act[4+OW:OW], act[OW-1:0], exp_v[v][4+OW:OW], exp_v[v][OW-1:0]);
         end
      end
   endtask

   task automatic idle_check(input string tag);
      acc_valid = 1'b0;
      @(negedge clk);
      for (int v = 0; v < 3; v++) begin
         n_tests++;
         if ({hv[v], hl[v], hn[v], hm[v], ms[v], of[v]} !== '0) begin
            n_fail++;
            $display("FAIL %s u%0d idle act v/l/n/m/x=%b ofs=%h exp all zero",
                     tag, v, {hv[v], hl[v], hn[v], hm[v], ms[v]}, of[v]);
         end
      end
   endtask

   task automatic cfg(input logic me, input logic [3:0] ls, input logic sm,
                      input logic [1:0] md, input logic mc);
      mem_en = me; lin_sel = ls; lin_small = sm; leg_mode = md; mmio_decode_en = mc;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, act=hung exp=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h2468_ACE1));
      bank0_ofs   = 22'h01_2000;
      bank1_ofs   = 22'h30_0000;
      pci_base_hi = 8'hE0;
      repeat (3) @(negedge clk);
      // R9: outputs are zero while in reset and just after
      idle_check("R9");
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R9");

      // R1: memory space disabled
      cfg(1'b0, 4'h0, 1'b0, 2'b01, 1'b1);
      access(32'h000A_0000, "R1");
      access(32'h000B_8000, "R1");
      cfg(1'b0, 4'h3, 1'b0, 2'b00, 1'b1);
      access(32'h0030_0000, "R1");

      // R2/R3: legacy windows, bank choice
      cfg(1'b1, 4'h0, 1'b0, 2'b00, 1'b0);
      access(32'h000A_0010, "R3");
      access(32'h000A_8004, "R3");
      access(32'h000A_FFFF, "R2");
      access(32'h000B_0000, "R2");
      cfg(1'b1, 4'h0, 1'b0, 2'b10, 1'b0);
      access(32'h000B_7FFF, "R2");
      access(32'h000B_8000, "R2");
      access(32'h000A_FFFF, "R2");
      cfg(1'b1, 4'h0, 1'b0, 2'b11, 1'b1);
      access(32'h000B_8000, "R4");
      access(32'h000B_FFFF, "R3");

      // R4: register window
      cfg(1'b1, 4'h0, 1'b0, 2'b01, 1'b1);
      access(32'h000B_8000, "R4");
      access(32'h000B_80FF, "R4");
      access(32'h000B_8100, "R4");
      cfg(1'b1, 4'h0, 1'b0, 2'b01, 1'b0);
      access(32'h000B_8010, "R4");
      cfg(1'b1, 4'h0, 1'b0, 2'b00, 1'b1);
      access(32'h000B_8010, "R4");

      // R5..R8: aperture
      cfg(1'b1, 4'h3, 1'b1, 2'b00, 1'b1);
      access(32'h0030_0000, "R5");
      access(32'h003F_FFFF, "R5");
      access(32'h0040_0000, "R5");
      access(32'h000A_0000, "R8");
      access(32'h000B_8020, "R4");
      cfg(1'b1, 4'h3, 1'b0, 2'b10, 1'b0);
      access(32'h0040_0000, "R5");
      access(32'h004F_FFFF, "R5");
      access(32'h000B_0000, "R8");
      access(32'hE000_0000, "R6");
      access(32'hE03F_FFFF, "R6");
      access(32'hE040_0000, "R6");
      access(32'h0800_1234, "R7");
      access(32'h0840_0000, "R7");

      // R9: configuration change between back-to-back accesses
      cfg(1'b1, 4'h0, 1'b0, 2'b00, 1'b0);
      access(32'h000A_9000, "R9");
      cfg(1'b1, 4'h5, 1'b1, 2'b00, 1'b0);
      access(32'h000A_9000, "R9");
      cfg(1'b0, 4'h5, 1'b1, 2'b00, 1'b0);
      access(32'h0050_0000, "R9");
      idle_check("R9");

      // Random mix
      for (int i = 0; i < 1500; i++) begin
         logic [AW-1:0] a;
         int r;
         mem_en         = ($urandom % 8) != 0;
         lin_sel        = (($urandom % 3) == 0) ? 4'($urandom % 16) : 4'h0;
         lin_small      = 1'($urandom % 2);
         leg_mode       = 2'($urandom % 4);
         mmio_decode_en = 1'($urandom % 2);
         pci_base_hi    = 8'($urandom % 256);
         bank0_ofs      = OW'($urandom);
         bank1_ofs      = OW'($urandom);
         r = $urandom % 5;
         case (r)
            0: a = 32'h000A_0000 + ($urandom % 32'h2_0000);
            1: a = {8'h0, lin_sel, 20'h0} + ($urandom % 32'h30_0000);
            2: a = {pci_base_hi, 24'h0} + ($urandom % 32'h50_0000);
            3: a = 32'h07F0_0000 + ($urandom % 32'h60_0000);
            default: a = 32'h000B_7F80 + ($urandom % 32'h200);
         endcase
         access(a, "");
         if ((i % 97) == 0) idle_check("R9");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule